// File: doc/BRIEF.md
# Address-Latched ROM Read Port

This block is the read side of a byte-wide read-only store that sits directly on a processor bus where address and data share the same lines. A strobe input decides where the address comes from. While the strobe is high, the address on the bus passes straight through to the storage array. While it is low, the block uses the last address it captured, so the processor can reuse the lines for data. Data is returned one clock after a valid address and enable pair. It is qualified by an output-valid flag (`data_oe`), which a pad ring or bus fabric turns into a tri-state enable.

Two select inputs control the output. A per-device select (`ce_n`) chooses the device, and a shared read strobe (`oe_n`) asks for data. Many instances can share one bus with a common `oe_n` and never drive at the same time. With the device deselected the block is in standby.

An identification input replaces array data with fixed codes: a maker code and a device code. Bit 0 of the effective address chooses between them. Storage contents come from a parameterised formula, so no data file is needed.

Top module: `romport_top`

## Requirements
- R1: After synchronous reset, `data_oe` is 0 and `data_out` is 0x00. The held address is 0, so a first read with the strobe low returns the word stored at address 0 (0xA5 with default parameters).
- R2: While `addr_strobe` is 1, the address on `addr_bus` in a cycle selects the word returned at the next clock edge. The held address also follows the bus.
- R3: While `addr_strobe` is 0, changes on `addr_bus` have no effect. Reads return the word at the last address seen while the strobe was high.
- R4: With `ce_n` = 1 (standby), `data_oe` is 0 and `data_out` is 0x00 whatever `oe_n` and `id_mode` are.
- R5: With `ce_n` = 0 and `oe_n` = 1, `data_oe` is 0 and `data_out` is 0x00.
- R6: When `ce_n` and `oe_n` are both 0 at a clock edge and still 0 afterwards, `data_oe` is 1 from that edge on.
- R7: When `id_mode` is 1 at the clock edge, the returned word is 0x20 if bit 0 of the effective address is 0, and 0x80 if it is 1. The same strobe rules as array reads apply.
- R8: `data_oe` falls in the same cycle that `ce_n` or `oe_n` rises, without waiting for a clock edge.
- R9: The array word at 15-bit address a is (a[7:0] XOR 0xA5) XOR {a[14:8], 1'b0}, with default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_bus | input | 15 | Shared address lines |
| addr_strobe | input | 1 | 1: address path transparent; 0: hold captured address |
| ce_n | input | 1 | Active-low device select; 1 puts the block in standby |
| oe_n | input | 1 | Active-low shared read strobe |
| id_mode | input | 1 | 1: return identification codes instead of array data |
| data_out | output | 8 | Read data, 0x00 when not driven |
| data_oe | output | 1 | Output-valid flag, drives the pad tri-state enable |

## Verification
A wrong held address shows at the port as the wrong word on the first strobe-low read. That is one clock after the strobe falls, since the latch output feeds the array with one register stage. A stuck or late enable register shows as `data_oe` missing in the cycle after both selects go low, or failing to drop at once when a select rises. A wrong source selection shows as an array word where 0x20 or 0x80 was expected, on the very next read.

// File: rtl/romport_pkg.sv
package romport_pkg;

  localparam logic [7:0] MAKER_CODE  = 8'h20;
  localparam logic [7:0] DEVICE_CODE = 8'h80;

  typedef enum logic {
    SRC_ARRAY = 1'b0,
    SRC_IDENT = 1'b1
  } rd_src_e;

endpackage

// File: rtl/romport_addr_latch.sv
module romport_addr_latch #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_eff
);

  logic [ADDR_W-1:0] addr_q;
  logic              strobe_q;
  logic              strobe_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (strobe) addr_q <= addr_in;
    end
  end

  assign strobe_fall = strobe_q & ~strobe;
  assign addr_eff    = strobe ? addr_in : addr_q;

  AST_TRACK_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    strobe |=> addr_q == $past(addr_in)); // R2

  AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(addr_q)); // R3

  AST_FALL_USES_HELD: assert property (@(posedge clk) disable iff (rst)
    strobe_fall |-> addr_eff == addr_q); // R3

endmodule

// File: rtl/romport_array.sv
module romport_array #(
  parameter int              ADDR_W  = 15,
  parameter int              DATA_W  = 8,
  parameter int              STORE_W = 8,
  parameter logic [DATA_W-1:0] SEED  = 8'hA5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << STORE_W;
  localparam int HI_W  = ADDR_W - STORE_W;
  localparam int MIX_W = HI_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] page_mix;
  logic [DATA_W-1:0] page_q;
  logic [MIX_W-1:0]  hi_shift;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(i) ^ SEED;
    end
  end

  assign hi_shift = {rd_addr[ADDR_W-1:STORE_W], 1'b0};

  generate
    if (MIX_W >= DATA_W) begin : g_mix_trunc
      assign page_mix = hi_shift[DATA_W-1:0];
    end else begin : g_mix_ext
      assign page_mix = {{(DATA_W-MIX_W){1'b0}}, hi_shift};
    end
  endgenerate

  always_ff @(posedge clk) begin
    mem_q  <= mem[rd_addr[STORE_W-1:0]];
    page_q <= page_mix;
  end

  assign rd_data = mem_q ^ page_q;

endmodule

// File: rtl/romport_read_ctrl.sv
module romport_read_ctrl
  import romport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              id_mode,
  input  logic              id_sel,
  input  logic [DATA_W-1:0] array_word,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic    en_q;
  rd_src_e src_q;
  logic    id_sel_q;
  logic    req_now;
  logic [DATA_W-1:0] word_sel;

  assign req_now = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      src_q    <= SRC_ARRAY;
      id_sel_q <= 1'b0;
    end else begin
      en_q     <= req_now;
      src_q    <= id_mode ? SRC_IDENT : SRC_ARRAY;
      id_sel_q <= id_sel;
    end
  end

  always_comb begin
    if (src_q == SRC_IDENT) begin
      word_sel = id_sel_q ? DATA_W'(DEVICE_CODE) : DATA_W'(MAKER_CODE);
    end else begin
      word_sel = array_word;
    end
  end

  assign data_oe  = en_q & req_now;
  assign data_out = data_oe ? word_sel : '0;

  AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!ce_n && !oe_n)); // R6

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (!data_oe && data_out == '0)); // R4

  AST_IDENT_CODES: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(id_mode)) |-> (data_out == DATA_W'(MAKER_CODE) || data_out == DATA_W'(DEVICE_CODE))); // R7

endmodule

// File: rtl/romport_top.sv
module romport_top #(
  parameter int              ADDR_W  = 15,
  parameter int              DATA_W  = 8,
  parameter int              STORE_W = 8,
  parameter logic [DATA_W-1:0] SEED  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_bus,
  input  logic              addr_strobe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              id_mode,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] array_word;

  romport_addr_latch #(.ADDR_W(ADDR_W)) i_latch (
    .clk      (clk),
    .rst      (rst),
    .strobe   (addr_strobe),
    .addr_in  (addr_bus),
    .addr_eff (addr_eff)
  );

  romport_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STORE_W(STORE_W),
    .SEED   (SEED)
  ) i_array (
    .clk     (clk),
    .rd_addr (addr_eff),
    .rd_data (array_word)
  );

  romport_read_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .id_mode    (id_mode),
    .id_sel     (addr_eff[0]),
    .array_word (array_word),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  AST_DESELECT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |-> !data_oe); // R8 R5

endmodule

// File: tb/test_romport_top.sv
module test_romport_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] addr_bus = '0;
  logic        addr_strobe = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        id_mode = 1'b0;
  logic [7:0]  data_out;
  logic        data_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  logic [14:0] m_held = '0;

  always #10 clk = ~clk;

  romport_top i_romport_top (
    .clk        (clk),
    .rst        (rst),
    .addr_bus   (addr_bus),
    .addr_strobe(addr_strobe),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .id_mode    (id_mode),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  function automatic logic [7:0] word_of(input logic [14:0] a);
    return (a[7:0] ^ 8'hA5) ^ {a[14:8], 1'b0};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual oe/data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [14:0] a, input logic s, input logic ce,
                      input logic oe, input logic id, input string tag);
    logic [14:0] eff;
    exp_t e;
    @(negedge clk);
    addr_bus = a; addr_strobe = s; ce_n = ce; oe_n = oe; id_mode = id;
    eff = s ? a : m_held;
    if (s) m_held = a;
    e.oe  = !ce && !oe;
    e.d   = !e.oe ? 8'h00 : (id ? (eff[0] ? 8'h80 : 8'h20) : word_of(eff));
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {data_oe, data_out}, {e.oe, e.d});
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset outputs", {data_oe, data_out}, 9'h000);
    @(negedge clk);
    rst = 1'b0;
    // R1: held address is 0 after reset
    step(15'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0, "R1 held zero");
    // R2 R6 R9: transparent reads across patterns
    step(15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R9 addr 0000");
    step(15'h7FFF, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R9 addr 7FFF");
    step(15'h1234, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R6 addr 1234");
    step(15'h4321, 1'b1, 1'b0, 1'b0, 1'b0, "R9 addr 4321");
    step(15'h00FF, 1'b1, 1'b0, 1'b0, 1'b0, "R9 addr 00FF");
    step(15'h7F00, 1'b1, 1'b0, 1'b0, 1'b0, "R9 addr 7F00");
    // R3: hold while strobe low
    step(15'h2ABC, 1'b1, 1'b0, 1'b0, 1'b0, "R2 addr 2ABC");
    step(15'h5555, 1'b0, 1'b0, 1'b0, 1'b0, "R3 hold vs 5555");
    step(15'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R3 hold vs 0001");
    step(15'h7FFE, 1'b0, 1'b0, 1'b0, 1'b0, "R3 hold vs 7FFE");
    // R4: standby with every oe_n/id_mode
    step(15'h0100, 1'b1, 1'b1, 1'b0, 1'b0, "R4 standby oe low");
    step(15'h0101, 1'b1, 1'b1, 1'b1, 1'b0, "R4 standby oe high");
    step(15'h0200, 1'b1, 1'b1, 1'b0, 1'b1, "R4 standby id");
    // R5: output disable
    step(15'h0300, 1'b1, 1'b0, 1'b1, 1'b0, "R5 disabled");
    step(15'h0300, 1'b1, 1'b0, 1'b1, 1'b1, "R5 disabled id");
    // R6: enable comes back after one edge
    step(15'h0300, 1'b1, 1'b0, 1'b0, 1'b0, "R6 re-enable");
    // R7: identification codes
    step(15'h0200, 1'b1, 1'b0, 1'b0, 1'b1, "R7 maker code");
    step(15'h0201, 1'b1, 1'b0, 1'b0, 1'b1, "R7 device code");
    step(15'h7FFE, 1'b0, 1'b0, 1'b0, 1'b1, "R7 held bit0 high");
    step(15'h0010, 1'b1, 1'b0, 1'b0, 1'b1, "R7 maker again");
    step(15'h0010, 1'b1, 1'b0, 1'b0, 1'b0, "R7 back to array");
    // R8: combinational drop when a select rises
    step(15'h0A0A, 1'b1, 1'b0, 1'b0, 1'b0, "R8 setup");
    step(15'h0A0A, 1'b1, 1'b1, 1'b0, 1'b0, "R8 ce rise edge");
    #2;
    check("R8 ce rise same cycle", {data_oe, data_out}, 9'h000);
    step(15'h0B0B, 1'b1, 1'b0, 1'b0, 1'b0, "R8 setup 2");
    step(15'h0B0B, 1'b1, 1'b0, 1'b0, 1'b0, "R8 steady");
    step(15'h0B0B, 1'b1, 1'b0, 1'b1, 1'b0, "R8 oe rise edge");
    #2;
    check("R8 oe rise same cycle", {data_oe, data_out}, 9'h000);
    // R1: reset clears the held address
    step(15'h3C3C, 1'b1, 1'b0, 1'b0, 1'b0, "R2 pre-reset");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    addr_strobe = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_held = '0;
    step(15'h3C3C, 1'b0, 1'b0, 1'b0, 1'b0, "R1 held cleared");
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule